// File: doc/BRIEF.md
# Dual-Bank Pointer Register Access Unit

This unit sits between a non-multiplexed host bus and two register banks of a peripheral: a DMA bank and a serial channel bank. Each bank has a single directly visible location, its command word, whose low five bits hold a register pointer. The host selects a register with two bus cycles. The first cycle writes the command word and loads the pointer. The next read or write cycle to the same bank goes to the register the pointer names. When that cycle ends, the pointer falls back to zero. The following access then reaches the command word again, so the command word can always be read or written in a single cycle.

Each bank has its own chip-select, pointer and controller. The read and write strobes and the data bus are shared. The register files stay outside the unit. For each bank the unit drives an address, a write enable, a read enable and write data, and it takes back read data. The top three bits of each command word are held in the unit and brought out as a command field for the bank.

Each bank controller is a four-state machine:
- ST_IDLE: the pointer is zero and the bank is waiting for a bus cycle.
- ST_CMD_ACC: a command-word access is in progress.
- ST_ARMED: the pointer is nonzero and the bank is waiting for the targeted cycle.
- ST_REG_ACC: a targeted register access is in progress.

The transitions are:
- "begin command access": ST_IDLE to ST_CMD_ACC when the bank is selected with a strobe.
- "arm": ST_CMD_ACC to ST_ARMED when the cycle ends with a nonzero pointer.
- "disarm": ST_CMD_ACC to ST_IDLE when the cycle ends with a zero pointer.
- "begin targeted access": ST_ARMED to ST_REG_ACC when the bank is selected with a strobe.
- "release": ST_REG_ACC to ST_IDLE when the cycle ends. The release also clears the pointer.

Top module: `dual_ptr_access`

## Requirements
- R1: A synchronous reset clears both pointers and both command fields to zero. After reset, a read of either bank returns 0x00.
- R2: A write to a bank whose pointer is zero stores data bits 4..0 as the pointer and bits 7..5 as that bank's command field, both in the first cycle of the access. A read with a zero pointer returns {command field, 5'b00000}.
- R3: In the first cycle of a write to a bank with a nonzero pointer, the unit asserts that bank's register write enable for exactly that cycle, with address equal to the pointer and the bus data on the write data lines. The pointer and the command field keep their values.
- R4: A read of a bank with a nonzero pointer asserts that bank's register read enable and places the bank's register read data on the read data bus.
- R5: A bus cycle ends on the first clock where the bank's chip-select or both strobes are low. One clock after a targeted cycle ends, the pointer is zero, so the next access reaches the command word.
- R6: A nonzero pointer keeps its value through any number of cycles in which its bank is not accessed.
- R7: An access to one bank never changes the other bank's pointer or command field.
- R8: A command-word write with pointer bits 00000 leaves the bank at its command word, so the following access is again a command-word access.
- R9: A cycle with both chip-selects high is ignored. No pointer, command field or register changes, and the read data bus is 0x00.
- R10: The read data bus is 0x00 whenever no read strobe is asserted for a selected bank. A selected bank with no strobe does not start an access.
- R11: A write whose strobe is held for several clocks produces a single register write enable pulse. If the write strobe and read strobe are both high, the cycle is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_cs | input | 1 | DMA bank chip-select |
| ser_cs | input | 1 | Serial bank chip-select |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, zero when no read |
| dma_cmd | output | 3 | DMA command field (command word bits 7..5) |
| dma_rf_addr | output | 5 | DMA register address, equal to the DMA pointer |
| dma_rf_we | output | 1 | DMA register write enable |
| dma_rf_re | output | 1 | DMA register read enable |
| dma_rf_wdata | output | 8 | DMA register write data |
| dma_rf_rdata | input | 8 | DMA register read data |
| ser_cmd | output | 3 | Serial command field (command word bits 7..5) |
| ser_rf_addr | output | 5 | Serial register address, equal to the serial pointer |
| ser_rf_we | output | 1 | Serial register write enable |
| ser_rf_re | output | 1 | Serial register read enable |
| ser_rf_wdata | output | 8 | Serial register write data |
| ser_rf_rdata | input | 8 | Serial register read data |

## Verification
A controller stuck in the wrong state, or a pointer that fails to clear, shows up on the very next access to that bank: a command-word read returns register data, or a register write lands on the command word and changes the command field output. A pointer changed by an access to the other bank appears when the armed bank's next targeted access reads or writes the wrong register. Register contents written back are read again through the bus, so that error becomes visible within two bus cycles. A repeated write enable during a long strobe is counted at the register port on the same clock.

// File: rtl/dap_pkg.sv
package dap_pkg;

    // Per-bank controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CMD_ACC = 2'd1,
        ST_ARMED   = 2'd2,
        ST_REG_ACC = 2'd3
    } bank_state_e;

    localparam int NUM_BANKS = 2;
    localparam int BANK_DMA  = 0;
    localparam int BANK_SER  = 1;

endpackage

// File: rtl/dap_sel_decode.sv
// Turns raw chip-selects into per-bank selects; more than one select
// asserted at once is a conflict and selects nothing.
module dap_sel_decode #(
    parameter int N = 2
) (
    input  logic [N-1:0] cs,
    output logic [N-1:0] sel
);

    logic at_most_one;

    always_comb begin
        at_most_one = ((cs & (cs - N'(1))) == '0);
        sel         = at_most_one ? cs : '0;
    end

endmodule

// File: rtl/dap_bank_ctrl.sv
// One bank: pointer, command field and access state machine.
module dap_bank_ctrl
    import dap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic                    rd_stb,
    input  logic                    wr_stb,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [DATA_W-1:0]       rf_rdata,
    output logic [PTR_W-1:0]        rf_addr,
    output logic                    rf_we,
    output logic                    rf_re,
    output logic [DATA_W-1:0]       rf_wdata,
    output logic [DATA_W-PTR_W-1:0] cmd_bits,
    output logic [DATA_W-1:0]       rd_data
);

    localparam int CMD_W = DATA_W - PTR_W;

    bank_state_e        state_q, state_d;
    logic [PTR_W-1:0]   ptr_q, ptr_d;
    logic [CMD_W-1:0]   cmd_q, cmd_d;

    logic active;
    logic is_wr;
    logic is_rd;
    logic reg_tgt;

    always_comb begin
        active = sel & (rd_stb | wr_stb);
        is_wr  = wr_stb;
        is_rd  = rd_stb & ~wr_stb;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pointer and command field
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cmd_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            cmd_q <= cmd_d;
        end
    end

    // Next state and datapath updates
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        cmd_d   = cmd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active) begin
                    state_d = ST_CMD_ACC;   // begin command access
                    if (is_wr) begin
                        ptr_d = wdata[PTR_W-1:0];
                        cmd_d = wdata[DATA_W-1:PTR_W];
                    end
                end
            end
            ST_CMD_ACC: begin
                if (!active) begin
                    // arm or disarm
                    state_d = (ptr_q != '0) ? ST_ARMED : ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (active) begin
                    state_d = ST_REG_ACC;   // begin targeted access
                end
            end
            ST_REG_ACC: begin
                if (!active) begin
                    state_d = ST_IDLE;      // release
                    ptr_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        rf_addr  = ptr_q;
        rf_wdata = wdata;
        cmd_bits = cmd_q;
        rf_we    = 1'b0;
        rf_re    = 1'b0;
        reg_tgt  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CMD_ACC: begin
                reg_tgt = 1'b0;
            end
            ST_ARMED: begin
                reg_tgt = 1'b1;
                rf_we   = active & is_wr;
                rf_re   = active & is_rd;
            end
            ST_REG_ACC: begin
                reg_tgt = 1'b1;
                rf_re   = active & is_rd;
            end
            default: begin
                reg_tgt = 1'b0;
            end
        endcase
        if (active && is_rd) begin
            rd_data = reg_tgt ? rf_rdata : {cmd_q, ptr_q};
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/dap_rd_merge.sv
// Combines the gated read data of all banks; at most one is nonzero.
module dap_rd_merge #(
    parameter int N = 2,
    parameter int W = 8
) (
    input  logic [N-1:0][W-1:0] bank_data,
    output logic [W-1:0]        dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | bank_data[i];
        end
    end

endmodule

// File: rtl/dual_ptr_access.sv
module dual_ptr_access
    import dap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dma_cs,
    input  logic                    ser_cs,
    input  logic                    rd_stb,
    input  logic                    wr_stb,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [DATA_W-PTR_W-1:0] dma_cmd,
    output logic [PTR_W-1:0]        dma_rf_addr,
    output logic                    dma_rf_we,
    output logic                    dma_rf_re,
    output logic [DATA_W-1:0]       dma_rf_wdata,
    input  logic [DATA_W-1:0]       dma_rf_rdata,
    output logic [DATA_W-PTR_W-1:0] ser_cmd,
    output logic [PTR_W-1:0]        ser_rf_addr,
    output logic                    ser_rf_we,
    output logic                    ser_rf_re,
    output logic [DATA_W-1:0]       ser_rf_wdata,
    input  logic [DATA_W-1:0]       ser_rf_rdata
);

    localparam int CMD_W = DATA_W - PTR_W;

    logic [NUM_BANKS-1:0]              cs_vec;
    logic [NUM_BANKS-1:0]              sel_vec;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  rf_rdata_vec;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  rf_wdata_vec;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  rd_data_vec;
    logic [NUM_BANKS-1:0][PTR_W-1:0]   rf_addr_vec;
    logic [NUM_BANKS-1:0][CMD_W-1:0]   cmd_vec;
    logic [NUM_BANKS-1:0]              rf_we_vec;
    logic [NUM_BANKS-1:0]              rf_re_vec;

    always_comb begin
        cs_vec[BANK_DMA]       = dma_cs;
        cs_vec[BANK_SER]       = ser_cs;
        rf_rdata_vec[BANK_DMA] = dma_rf_rdata;
        rf_rdata_vec[BANK_SER] = ser_rf_rdata;
    end

    dap_sel_decode #(
        .N (NUM_BANKS)
    ) u_decode (
        .cs  (cs_vec),
        .sel (sel_vec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dap_bank_ctrl #(
            .DATA_W (DATA_W),
            .PTR_W  (PTR_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .sel      (sel_vec[b]),
            .rd_stb   (rd_stb),
            .wr_stb   (wr_stb),
            .wdata    (wdata),
            .rf_rdata (rf_rdata_vec[b]),
            .rf_addr  (rf_addr_vec[b]),
            .rf_we    (rf_we_vec[b]),
            .rf_re    (rf_re_vec[b]),
            .rf_wdata (rf_wdata_vec[b]),
            .cmd_bits (cmd_vec[b]),
            .rd_data  (rd_data_vec[b])
        );
    end

    dap_rd_merge #(
        .N (NUM_BANKS),
        .W (DATA_W)
    ) u_merge (
        .bank_data (rd_data_vec),
        .dout      (rdata)
    );

    always_comb begin
        dma_cmd      = cmd_vec[BANK_DMA];
        dma_rf_addr  = rf_addr_vec[BANK_DMA];
        dma_rf_we    = rf_we_vec[BANK_DMA];
        dma_rf_re    = rf_re_vec[BANK_DMA];
        dma_rf_wdata = rf_wdata_vec[BANK_DMA];
        ser_cmd      = cmd_vec[BANK_SER];
        ser_rf_addr  = rf_addr_vec[BANK_SER];
        ser_rf_we    = rf_we_vec[BANK_SER];
        ser_rf_re    = rf_re_vec[BANK_SER];
        ser_rf_wdata = rf_wdata_vec[BANK_SER];
    end

endmodule

// File: rtl/dap_checker.sv
module dap_checker #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    dma_cs,
    input logic                    ser_cs,
    input logic                    rd_stb,
    input logic [DATA_W-1:0]       rdata,
    input logic [DATA_W-PTR_W-1:0] dma_cmd,
    input logic [PTR_W-1:0]        dma_rf_addr,
    input logic                    dma_rf_we,
    input logic [DATA_W-PTR_W-1:0] ser_cmd,
    input logic [PTR_W-1:0]        ser_rf_addr,
    input logic                    ser_rf_we
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (dma_rf_addr == '0 && ser_rf_addr == '0 && dma_cmd == '0 && ser_cmd == '0));

    // R11
    dma_single_we_chk: assert property (@(posedge clk) disable iff (rst)
        dma_rf_we |=> !dma_rf_we);

    // R11
    ser_single_we_chk: assert property (@(posedge clk) disable iff (rst)
        ser_rf_we |=> !ser_rf_we);

    // R3
    dma_we_needs_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        dma_rf_we |-> (dma_rf_addr != '0));

    // R7
    ser_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (!ser_cs && !$past(ser_cs)) |=> ($stable(ser_rf_addr) && $stable(ser_cmd)));

    // R7
    dma_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (!dma_cs && !$past(dma_cs)) |=> ($stable(dma_rf_addr) && $stable(dma_cmd)));

    // R9
    conflict_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_cs && ser_cs) |-> (rdata == '0 && !dma_rf_we && !ser_rf_we));

    // R10
    no_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> (rdata == '0));

endmodule

bind dual_ptr_access dap_checker #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W)
) u_dap_checker (
    .clk         (clk),
    .rst         (rst),
    .dma_cs      (dma_cs),
    .ser_cs      (ser_cs),
    .rd_stb      (rd_stb),
    .rdata       (rdata),
    .dma_cmd     (dma_cmd),
    .dma_rf_addr (dma_rf_addr),
    .dma_rf_we   (dma_rf_we),
    .ser_cmd     (ser_cmd),
    .ser_rf_addr (ser_rf_addr),
    .ser_rf_we   (ser_rf_we)
);

// File: tb/test_dual_ptr_access.sv
`timescale 1ns/1ps
module test_dual_ptr_access;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dma_cs = 1'b0;
    logic       ser_cs = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] dma_cmd, ser_cmd;
    logic [4:0] dma_rf_addr, ser_rf_addr;
    logic       dma_rf_we, dma_rf_re, ser_rf_we, ser_rf_re;
    logic [7:0] dma_rf_wdata, ser_rf_wdata, dma_rf_rdata, ser_rf_rdata;

    int vec_cnt  = 0;
    int fail_cnt = 0;
    int we_cnt   = 0;
    bit done     = 1'b0;

    logic [7:0] dma_mem [32];
    logic [7:0] ser_mem [32];

    always #10 clk = ~clk;

    dual_ptr_access i_dual_ptr_access (
        .clk          (clk),
        .rst          (rst),
        .dma_cs       (dma_cs),
        .ser_cs       (ser_cs),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .wdata        (wdata),
        .rdata        (rdata),
        .dma_cmd      (dma_cmd),
        .dma_rf_addr  (dma_rf_addr),
        .dma_rf_we    (dma_rf_we),
        .dma_rf_re    (dma_rf_re),
        .dma_rf_wdata (dma_rf_wdata),
        .dma_rf_rdata (dma_rf_rdata),
        .ser_cmd      (ser_cmd),
        .ser_rf_addr  (ser_rf_addr),
        .ser_rf_we    (ser_rf_we),
        .ser_rf_re    (ser_rf_re),
        .ser_rf_wdata (ser_rf_wdata),
        .ser_rf_rdata (ser_rf_rdata)
    );

    // Register file models behind the two banks
    assign dma_rf_rdata = dma_mem[dma_rf_addr];
    assign ser_rf_rdata = ser_mem[ser_rf_addr];

    always @(posedge clk) begin
        if (dma_rf_we) begin
            dma_mem[dma_rf_addr] <= dma_rf_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (ser_rf_we) begin
            ser_mem[ser_rf_addr] <= ser_rf_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    // Vector: {bank(0 dma,1 ser), wr, exp_we, data[7:0], exp_rdata[7:0]}
    localparam logic [18:0] VEC [0:21] = '{
        {1'b0, 1'b1, 1'b0, 8'h03, 8'h00},  // dma cmd: ptr 3            R2
        {1'b0, 1'b1, 1'b1, 8'hA5, 8'h00},  // dma reg3 <= A5            R3
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h00},  // dma cmd read               R5
        {1'b1, 1'b1, 1'b0, 8'h07, 8'h00},  // ser cmd: ptr 7            R2
        {1'b0, 1'b1, 1'b0, 8'h03, 8'h00},  // dma cmd: ptr 3            R2
        {1'b1, 1'b1, 1'b1, 8'h3C, 8'h00},  // ser reg7 <= 3C            R3 R7
        {1'b0, 1'b0, 1'b0, 8'h00, 8'hA5},  // dma reg3 read             R4 R6 R7
        {1'b1, 1'b1, 1'b0, 8'h07, 8'h00},  // ser cmd: ptr 7
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h3C},  // ser reg7 read             R4
        {1'b0, 1'b1, 1'b0, 8'h41, 8'h00},  // dma cmd=010 ptr 1         R2
        {1'b0, 1'b1, 1'b1, 8'h99, 8'h00},  // dma reg1 <= 99            R3
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h40},  // dma cmd read: 40          R2 R3 R5
        {1'b0, 1'b1, 1'b0, 8'h41, 8'h00},  // dma cmd=010 ptr 1
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h99},  // dma reg1 read             R4
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h40},  // dma cmd read              R5
        {1'b1, 1'b1, 1'b0, 8'hE0, 8'h00},  // ser cmd=111 ptr 0         R8
        {1'b1, 1'b0, 1'b0, 8'h00, 8'hE0},  // still cmd word            R8
        {1'b1, 1'b1, 1'b0, 8'hFF, 8'h00},  // ser cmd=111 ptr 31        R2
        {1'b1, 1'b1, 1'b1, 8'h77, 8'h00},  // ser reg31 <= 77           R3 R11
        {1'b1, 1'b1, 1'b0, 8'hFF, 8'h00},  // ser cmd=111 ptr 31
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h77},  // ser reg31 read            R4
        {1'b1, 1'b0, 1'b0, 8'h00, 8'hE0}   // ser cmd read              R5
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: strobe held 'hold' clocks, then one idle clock
    task automatic access(input bit to_ser, input bit both, input bit wr,
                          input logic [7:0] d, input int hold,
                          output logic [7:0] rd_v, output int we_d);
        int w0;
        w0 = we_cnt;
        @(negedge clk);
        dma_cs = both | ~to_ser;
        ser_cs = both | to_ser;
        wr_stb = wr;
        rd_stb = ~wr;
        wdata  = d;
        repeat (hold - 1) @(negedge clk);
        #2 rd_v = rdata;
        @(negedge clk);
        dma_cs = 1'b0;
        ser_cs = 1'b0;
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        @(negedge clk);
        we_d = we_cnt - w0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
        $finish;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fail_cnt++;
            $display("FAIL watchdog R1..R11 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rv;
        int wd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 dma_cmd", {5'd0, dma_cmd}, 8'h00);
        chk("R1 ser_cmd", {5'd0, ser_cmd}, 8'h00);
        chk("R10 idle rdata", rdata, 8'h00);
        access(1'b0, 1'b0, 1'b0, 8'h00, 1, rv, wd);
        chk("R1 dma read after reset", rv, 8'h00);
        access(1'b1, 1'b0, 1'b0, 8'h00, 2, rv, wd);
        chk("R1 ser read after reset", rv, 8'h00);

        // R9: both chip-selects ignored
        access(1'b0, 1'b1, 1'b1, 8'hE2, 1, rv, wd);
        chk("R9 conflict write no we", 8'(wd), 8'h00);
        access(1'b0, 1'b1, 1'b0, 8'h00, 1, rv, wd);
        chk("R9 conflict read rdata", rv, 8'h00);
        access(1'b0, 1'b0, 1'b0, 8'h00, 1, rv, wd);
        chk("R9 dma cmd untouched", rv, 8'h00);
        access(1'b1, 1'b0, 1'b0, 8'h00, 1, rv, wd);
        chk("R9 ser cmd untouched", rv, 8'h00);

        // R10 / R6: select without strobe does not consume an armed pointer
        access(1'b0, 1'b0, 1'b1, 8'h02, 1, rv, wd);
        @(negedge clk);
        dma_cs = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 selected no strobe rdata", rdata, 8'h00);
        dma_cs = 1'b0;
        repeat (5) @(negedge clk);
        access(1'b0, 1'b0, 1'b1, 8'h5A, 3, rv, wd);
        chk("R6 R11 armed write one we", 8'(wd), 8'h01);
        access(1'b0, 1'b0, 1'b1, 8'h02, 1, rv, wd);
        access(1'b0, 1'b0, 1'b0, 8'h00, 2, rv, wd);
        chk("R6 R4 reg2 readback", rv, 8'h5A);

        // Vector table
        for (int i = 0; i < 22; i++) begin
            logic [18:0] v;
            v = VEC[i];
            access(v[18], 1'b0, v[17], v[15:8], (i % 3) + 1, rv, wd);
            if (v[17]) begin
                chk($sformatf("R3 R11 vec%0d we count", i), 8'(wd), {7'd0, v[16]});
            end else begin
                chk($sformatf("R4 R5 R7 R8 vec%0d rdata", i), rv, v[7:0]);
            end
        end

        // R2: command fields on the ports
        chk("R2 dma_cmd", {5'd0, dma_cmd}, 8'h02);
        chk("R2 ser_cmd", {5'd0, ser_cmd}, 8'h07);

        // R11: read and write strobes together act as a write
        access(1'b0, 1'b0, 1'b1, 8'h45, 1, rv, wd);
        @(negedge clk);
        dma_cs = 1'b1; wr_stb = 1'b1; rd_stb = 1'b1; wdata = 8'hC3;
        @(negedge clk);
        dma_cs = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
        @(negedge clk);
        access(1'b0, 1'b0, 1'b1, 8'h45, 1, rv, wd);
        access(1'b0, 1'b0, 1'b0, 8'h00, 1, rv, wd);
        chk("R11 rd+wr treated as write", rv, 8'hC3);

        // R1: reset while armed
        access(1'b0, 1'b0, 1'b1, 8'h64, 1, rv, wd);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(1'b0, 1'b0, 1'b0, 8'h00, 1, rv, wd);
        chk("R1 reset disarms", rv, 8'h00);
        chk("R1 reset clears cmd", {5'd0, dma_cmd}, 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule